// File: doc/BRIEF.md
# NAND page program sequencer

This block sits on the host side of an 8-bit asynchronous NAND flash bus and carries out one page program operation per request. A request names the target row (block and page), the column where loading begins and the number of data bytes to load. The bytes then arrive on a separate stream. Any byte of that stream may carry a column jump, which moves the device's load pointer elsewhere in the page before that byte is written. The sequencer drives the command latch, address latch, write strobe and data lines for each bus cycle. It issues the load command, the address bytes, the data, any column jump commands and the confirm command. It then polls the device status until the device reports ready, and returns pass, fail, timeout or reject on a one-cycle done pulse.

Bus strobe widths, the delay after confirm, the polling interval and the timeout are counter parameters. A small table remembers the last page accepted in each tracked block. A request that would program the same page again, or a lower page in a block, is refused before any bus activity takes place. Requests with no data, or with more data than a page register holds, are refused in the same way.

Top module: `nand_prog_seq`

## Requirements
- R1: An accepted request starts with command 80h, followed by exactly five address cycles in this order: column bits [7:0], column bits [15:8], row bits [7:0], row bits [15:8], row bits [23:16].
- R2: After the address cycles, the stream bytes are written as data cycles (CLE and ALE both low) in stream order, and their number equals the request length.
- R3: A stream byte flagged with `din_jump` is preceded on the bus by command 85h and two address cycles carrying `din_col` bits [7:0] and then bits [15:8]. A jump may occur before the first byte and any number of times.
- R4: After the last data byte, command 10h is issued exactly once. A request with length 0 or a length above 17664 is refused with result 3 (reject), and no bus cycle is produced.
- R5: After the 10h command and a wait of T_WB cycles, command 70h is written once. Status reads (RE# strobes) then repeat, with successive reads starting T_LOW + T_HIGH + 1 + POLL_INT cycles apart. No command other than 70h is written before the result is reported.
- R6: A status byte is evaluated only when its bit 6 (ready) is 1. Then bit 0 selects result 1 (fail) when set, and result 0 (pass) when clear. While bit 6 is 0, bit 0 is ignored.
- R7: If the device has not reported ready when a polling interval ends at least TIMEOUT cycles after confirm, the result is 2 (timeout).
- R8: The page is row bits [PAGE_W-1:0] and the tracked block is row bits [PAGE_W+TBL_W-1:PAGE_W]. A request whose page is less than or equal to the last page accepted for its block is refused with result 3, and no bus cycle is produced. Higher pages and other blocks are accepted.
- R9: CLE and ALE are never high together. The data output enable is low while RE# is low and high while WE# is low. When the sequencer is idle, WE# and RE# are high and CLE and ALE are low.
- R10: `done_valid` is high for exactly one cycle per request. `req_ready` is high in the cycle after it and whenever no request is in progress, including right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Program request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_row | input | 24 | Row address (block and page) |
| req_col | input | 16 | Starting column |
| req_len | input | 15 | Number of data bytes |
| din_valid | input | 1 | Stream byte present |
| din_ready | output | 1 | Stream byte taken this cycle |
| din_data | input | 8 | Stream byte |
| din_jump | input | 1 | Move the column pointer before this byte |
| din_col | input | 16 | New column for a flagged byte |
| done_valid | output | 1 | Result pulse |
| done_result | output | 2 | 0 pass, 1 fail, 2 timeout, 3 reject |
| nd_cle | output | 1 | Command latch enable |
| nd_ale | output | 1 | Address latch enable |
| nd_we_n | output | 1 | Write strobe, active low |
| nd_re_n | output | 1 | Read strobe, active low |
| nd_dq_out | output | 8 | Bus value driven to the device |
| nd_dq_oe | output | 1 | Drive enable for nd_dq_out |
| nd_dq_in | input | 8 | Bus value from the device |

## Verification
The main program flow is tried with a contiguous load, with column jumps both ahead of the first byte and in the middle of the stream, and with a full-size 17664-byte load. These show whether the pointer commands are placed before the correct byte, and whether the length counter stops at the page boundary. The status model holds the device busy for a chosen number of reads and returns bit 0 set while busy. This separates a design that decodes the fail bit only after ready from one that reads it too early. A device that never becomes ready exercises the timeout. Repeated, lower and higher page requests in one block, compared with requests to fresh blocks, show whether the order table refuses exactly the pages it should.

// File: rtl/nand_prog_pkg.sv
package nand_prog_pkg;

    localparam int COL_W     = 16;
    localparam int ROW_W     = 24;
    localparam int ADDR_CYC  = 5;
    localparam int MAX_BYTES = 17664;
    localparam int LEN_W     = 15;

    localparam logic [7:0] CMD_LOAD    = 8'h80;
    localparam logic [7:0] CMD_COLJMP  = 8'h85;
    localparam logic [7:0] CMD_CONFIRM = 8'h10;
    localparam logic [7:0] CMD_STATUS  = 8'h70;

    localparam int SR_READY = 6;
    localparam int SR_FAIL  = 0;

    typedef enum logic [1:0] {
        BUS_CMD,
        BUS_ADR,
        BUS_DAT,
        BUS_RD
    } bus_op_e;

    typedef struct packed {
        bus_op_e    op;
        logic [7:0] val;
    } bus_req_t;

    typedef enum logic [1:0] {
        RES_PASS    = 2'd0,
        RES_FAIL    = 2'd1,
        RES_TIMEOUT = 2'd2,
        RES_REJECT  = 2'd3
    } result_e;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_LOAD,
        SQ_ADDR,
        SQ_DATA,
        SQ_JCMD,
        SQ_JADDR,
        SQ_CONF,
        SQ_WAITB,
        SQ_STCMD,
        SQ_POLL,
        SQ_GAP,
        SQ_DONE
    } seq_e;

    // Address cycle byte: column low, column high, then row low to high.
    function automatic logic [7:0] addr_byte(input logic [COL_W-1:0] col,
                                             input logic [ROW_W-1:0] row,
                                             input logic [2:0]       idx);
        logic [7:0] b;
        unique case (idx)
            3'd0:    b = col[7:0];
            3'd1:    b = col[15:8];
            3'd2:    b = row[7:0];
            3'd3:    b = row[15:8];
            3'd4:    b = row[23:16];
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/nand_bus_cyc.sv
module nand_bus_cyc
    import nand_prog_pkg::*;
#(
    parameter int T_LOW  = 2,
    parameter int T_HIGH = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  bus_req_t   req,
    output logic       busy,
    output logic       done,
    output logic [7:0] rd_byte,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic [7:0] dq_out,
    output logic       dq_oe,
    input  logic [7:0] dq_in
);

    localparam int TMAX = (T_LOW > T_HIGH) ? T_LOW : T_HIGH;
    localparam int CW   = $clog2(TMAX + 1);

    typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_e;

    phase_e   ph;
    logic [CW-1:0] cnt;
    bus_req_t cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            cnt     <= '0;
            cur     <= '0;
            rd_byte <= '0;
        end else begin
            unique case (ph)
                PH_IDLE: begin
                    if (start) begin
                        cur <= req;
                        cnt <= '0;
                        ph  <= PH_LOW;
                    end
                end
                PH_LOW: begin
                    if (cnt == CW'(T_LOW - 1)) begin
                        cnt <= '0;
                        ph  <= PH_HIGH;
                        if (cur.op == BUS_RD) rd_byte <= dq_in;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (cnt == CW'(T_HIGH - 1)) ph <= PH_IDLE;
                    else                        cnt <= cnt + 1'b1;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign busy   = (ph != PH_IDLE);
    assign done   = (ph == PH_HIGH) && (cnt == CW'(T_HIGH - 1));
    assign cle    = busy && (cur.op == BUS_CMD);
    assign ale    = busy && (cur.op == BUS_ADR);
    assign we_n   = !((ph == PH_LOW) && (cur.op != BUS_RD));
    assign re_n   = !((ph == PH_LOW) && (cur.op == BUS_RD));
    assign dq_oe  = busy && (cur.op != BUS_RD);
    assign dq_out = dq_oe ? cur.val : 8'h00;

endmodule

// File: rtl/nand_order_tbl.sv
module nand_order_tbl #(
    parameter int PAGE_W = 8,
    parameter int TBL_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TBL_W-1:0]  chk_blk,
    input  logic [PAGE_W-1:0] chk_page,
    output logic              bad,
    input  logic              upd
);

    localparam int ENTRIES = 1 << TBL_W;

    logic [ENTRIES-1:0] vld;
    logic [PAGE_W-1:0]  last [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                vld[e]  <= 1'b0;
                last[e] <= '0;
            end else if (upd && (chk_blk == TBL_W'(e))) begin
                vld[e]  <= 1'b1;
                last[e] <= chk_page;
            end
        end
    end

    assign bad = vld[chk_blk] && (chk_page <= last[chk_blk]);

endmodule

// File: rtl/nand_prog_seq.sv
module nand_prog_seq
    import nand_prog_pkg::*;
#(
    parameter int T_LOW    = 2,
    parameter int T_HIGH   = 2,
    parameter int T_WB     = 4,
    parameter int POLL_INT = 8,
    parameter int TIMEOUT  = 400,
    parameter int PAGE_W   = 8,
    parameter int TBL_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [LEN_W-1:0] req_len,
    input  logic             din_valid,
    output logic             din_ready,
    input  logic [7:0]       din_data,
    input  logic             din_jump,
    input  logic [COL_W-1:0] din_col,
    output logic             done_valid,
    output logic [1:0]       done_result,
    output logic             nd_cle,
    output logic             nd_ale,
    output logic             nd_we_n,
    output logic             nd_re_n,
    output logic [7:0]       nd_dq_out,
    output logic             nd_dq_oe,
    input  logic [7:0]       nd_dq_in
);

    localparam int WMAX = (T_WB > POLL_INT) ? T_WB : POLL_INT;
    localparam int WW   = $clog2(WMAX + 1);
    localparam int TW   = $clog2(TIMEOUT + 1);

    seq_e             st;
    result_e          result_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [LEN_W-1:0] rem;
    logic [2:0]       aidx;
    logic             jmp_ok;
    logic [WW-1:0]    wait_cnt;
    logic [TW-1:0]    tmo_cnt;

    bus_req_t   breq;
    logic       bstart;
    logic       bus_busy;
    logic       bus_done;
    logic [7:0] rd_byte;
    logic       unused_rd;

    logic len_bad;
    logic order_bad;
    logic tbl_upd;
    logic din_fire;
    logic jump_go;
    logic post_conf;

    assign unused_rd = ^rd_byte;

    assign len_bad   = (req_len == '0) || (req_len > LEN_W'(MAX_BYTES));
    assign tbl_upd   = (st == SQ_IDLE) && req_valid && !len_bad && !order_bad;
    assign din_fire  = din_valid && din_ready;
    assign jump_go   = (st == SQ_DATA) && din_valid && din_jump && !jmp_ok
                       && !bus_busy && (rem != '0);
    assign post_conf = (st == SQ_WAITB) || (st == SQ_STCMD) ||
                       (st == SQ_POLL)  || (st == SQ_GAP);

    assign req_ready   = (st == SQ_IDLE);
    assign done_valid  = (st == SQ_DONE);
    assign done_result = result_q;

    always_comb begin
        breq      = '{op: BUS_CMD, val: 8'h00};
        bstart    = 1'b0;
        din_ready = 1'b0;
        unique case (st)
            SQ_LOAD: begin
                bstart   = 1'b1;
                breq.val = CMD_LOAD;
            end
            SQ_ADDR: begin
                bstart   = 1'b1;
                breq.op  = BUS_ADR;
                breq.val = addr_byte(col_q, row_q, aidx);
            end
            SQ_DATA: begin
                din_ready = !bus_busy && (rem != '0) && (!din_jump || jmp_ok);
                bstart    = din_valid && din_ready;
                breq.op   = BUS_DAT;
                breq.val  = din_data;
            end
            SQ_JCMD: begin
                bstart   = 1'b1;
                breq.val = CMD_COLJMP;
            end
            SQ_JADDR: begin
                bstart   = 1'b1;
                breq.op  = BUS_ADR;
                breq.val = aidx[0] ? col_q[15:8] : col_q[7:0];
            end
            SQ_CONF: begin
                bstart   = 1'b1;
                breq.val = CMD_CONFIRM;
            end
            SQ_STCMD: begin
                bstart   = 1'b1;
                breq.val = CMD_STATUS;
            end
            SQ_POLL: begin
                bstart  = 1'b1;
                breq.op = BUS_RD;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SQ_IDLE;
            result_q <= RES_PASS;
            row_q    <= '0;
            col_q    <= '0;
            rem      <= '0;
            aidx     <= '0;
            jmp_ok   <= 1'b0;
            wait_cnt <= '0;
            tmo_cnt  <= '0;
        end else begin
            if (post_conf && (tmo_cnt != TW'(TIMEOUT))) tmo_cnt <= tmo_cnt + 1'b1;

            unique case (st)
                SQ_IDLE: begin
                    if (req_valid) begin
                        if (len_bad || order_bad) begin
                            result_q <= RES_REJECT;
                            st       <= SQ_DONE;
                        end else begin
                            row_q <= req_row;
                            col_q <= req_col;
                            rem   <= req_len;
                            aidx  <= '0;
                            st    <= SQ_LOAD;
                        end
                    end
                end
                SQ_LOAD: if (bus_done) st <= SQ_ADDR;
                SQ_ADDR: begin
                    if (bus_done) begin
                        if (aidx == 3'(ADDR_CYC - 1)) begin
                            jmp_ok <= 1'b0;
                            st     <= SQ_DATA;
                        end else begin
                            aidx <= aidx + 1'b1;
                        end
                    end
                end
                SQ_DATA: begin
                    if (din_fire) begin
                        rem    <= rem - 1'b1;
                        jmp_ok <= 1'b0;
                    end else if (jump_go) begin
                        col_q <= din_col;
                        aidx  <= '0;
                        st    <= SQ_JCMD;
                    end else if (bus_done && (rem == '0)) begin
                        st <= SQ_CONF;
                    end
                end
                SQ_JCMD: if (bus_done) st <= SQ_JADDR;
                SQ_JADDR: begin
                    if (bus_done) begin
                        if (aidx[0]) begin
                            jmp_ok <= 1'b1;
                            st     <= SQ_DATA;
                        end else begin
                            aidx <= 3'd1;
                        end
                    end
                end
                SQ_CONF: begin
                    if (bus_done) begin
                        wait_cnt <= '0;
                        tmo_cnt  <= '0;
                        st       <= SQ_WAITB;
                    end
                end
                SQ_WAITB: begin
                    if (wait_cnt == WW'(T_WB - 1)) st <= SQ_STCMD;
                    else                           wait_cnt <= wait_cnt + 1'b1;
                end
                SQ_STCMD: if (bus_done) st <= SQ_POLL;
                SQ_POLL: begin
                    if (bus_done) begin
                        if (rd_byte[SR_READY]) begin
                            result_q <= rd_byte[SR_FAIL] ? RES_FAIL : RES_PASS;
                            st       <= SQ_DONE;
                        end else begin
                            wait_cnt <= '0;
                            st       <= SQ_GAP;
                        end
                    end
                end
                SQ_GAP: begin
                    if (wait_cnt == WW'(POLL_INT - 1)) begin
                        if (tmo_cnt == TW'(TIMEOUT)) begin
                            result_q <= RES_TIMEOUT;
                            st       <= SQ_DONE;
                        end else begin
                            st <= SQ_POLL;
                        end
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                SQ_DONE: st <= SQ_IDLE;
                default: st <= SQ_IDLE;
            endcase
        end
    end

    nand_bus_cyc #(
        .T_LOW  (T_LOW),
        .T_HIGH (T_HIGH)
    ) u_bus (
        .clk     (clk),
        .rst     (rst),
        .start   (bstart),
        .req     (breq),
        .busy    (bus_busy),
        .done    (bus_done),
        .rd_byte (rd_byte),
        .cle     (nd_cle),
        .ale     (nd_ale),
        .we_n    (nd_we_n),
        .re_n    (nd_re_n),
        .dq_out  (nd_dq_out),
        .dq_oe   (nd_dq_oe),
        .dq_in   (nd_dq_in)
    );

    nand_order_tbl #(
        .PAGE_W (PAGE_W),
        .TBL_W  (TBL_W)
    ) u_order (
        .clk      (clk),
        .rst      (rst),
        .chk_blk  (req_row[PAGE_W +: TBL_W]),
        .chk_page (req_row[PAGE_W-1:0]),
        .bad      (order_bad),
        .upd      (tbl_upd)
    );

endmodule

// File: rtl/nand_prog_seq_chk.sv
module nand_prog_seq_chk
    import nand_prog_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input seq_e       st,
    input logic       req_ready,
    input logic       done_valid,
    input logic [1:0] done_result,
    input logic       nd_cle,
    input logic       nd_ale,
    input logic       nd_we_n,
    input logic       nd_re_n,
    input logic [7:0] nd_dq_out,
    input logic       nd_dq_oe
);

    AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(nd_cle && nd_ale)) else $error("cle and ale together"); // R9

    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        !nd_re_n |-> !nd_dq_oe) else $error("bus driven during read"); // R9

    AST_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !nd_we_n |-> nd_dq_oe) else $error("write strobe without drive"); // R9

    AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_IDLE) |-> (nd_we_n && nd_re_n && !nd_cle && !nd_ale))
        else $error("bus active while idle"); // R9

    AST_BUSY_STATUS_ONLY: assert property (@(posedge clk) disable iff (rst)
        ((st == SQ_WAITB || st == SQ_STCMD || st == SQ_POLL || st == SQ_GAP)
         && nd_cle && !nd_we_n) |-> (nd_dq_out == CMD_STATUS))
        else $error("non-status command while programming"); // R5

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid) else $error("done longer than a cycle"); // R10

    AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> req_ready) else $error("not ready after done"); // R10

    AST_SHORT_PATH_REJECT: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_DONE && $past(st) == SQ_IDLE) |-> (done_result == RES_REJECT))
        else $error("direct finish without reject code"); // R8

endmodule

bind nand_prog_seq nand_prog_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .st          (st),
    .req_ready   (req_ready),
    .done_valid  (done_valid),
    .done_result (done_result),
    .nd_cle      (nd_cle),
    .nd_ale      (nd_ale),
    .nd_we_n     (nd_we_n),
    .nd_re_n     (nd_re_n),
    .nd_dq_out   (nd_dq_out),
    .nd_dq_oe    (nd_dq_oe)
);

// File: tb/nand_prog_seq_tb.sv
module nand_prog_seq_tb;
    import nand_prog_pkg::*;

    localparam int T_LOW    = 2;
    localparam int T_HIGH   = 2;
    localparam int POLL_INT = 8;
    localparam int POLL_GAP = T_LOW + T_HIGH + 1 + POLL_INT;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_row = '0;
    logic [15:0] req_col = '0;
    logic [14:0] req_len = '0;
    logic        din_valid = 1'b0;
    logic        din_ready;
    logic [7:0]  din_data = '0;
    logic        din_jump = 1'b0;
    logic [15:0] din_col = '0;
    logic        done_valid;
    logic [1:0]  done_result;
    logic        nd_cle, nd_ale, nd_we_n, nd_re_n, nd_dq_oe;
    logic [7:0]  nd_dq_out;
    logic [7:0]  nd_dq_in;

    nand_prog_seq u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_row(req_row), .req_col(req_col), .req_len(req_len),
        .din_valid(din_valid), .din_ready(din_ready), .din_data(din_data),
        .din_jump(din_jump), .din_col(din_col),
        .done_valid(done_valid), .done_result(done_result),
        .nd_cle(nd_cle), .nd_ale(nd_ale), .nd_we_n(nd_we_n), .nd_re_n(nd_re_n),
        .nd_dq_out(nd_dq_out), .nd_dq_oe(nd_dq_oe), .nd_dq_in(nd_dq_in)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_tests = 0;
    int n_fail  = 0;

    // device model: logs write cycles, answers status reads
    logic       clr_log = 1'b0;
    int         ready_after = 0;
    logic       fail_flag = 1'b0;
    int         ev_kind [64];
    logic [7:0] ev_byte [64];
    int         ev_n = 0, dat_n = 0, cmd70_n = 0, rd_n = 0, rd_t0 = 0, rd_t1 = 0;
    logic       we_d = 1'b1, re_d = 1'b1;

    assign nd_dq_in = (rd_n > ready_after) ? {1'b0, 1'b1, 5'b0, fail_flag} : 8'h01;

    always @(negedge clk) begin
        if (rst || clr_log) begin
            ev_n = 0; dat_n = 0; cmd70_n = 0; rd_n = 0; rd_t0 = 0; rd_t1 = 0;
            we_d = 1'b1; re_d = 1'b1;
        end else begin
            if (nd_we_n && !we_d) begin
                if (ev_n < 64) begin
                    ev_kind[ev_n] = nd_cle ? 0 : (nd_ale ? 1 : 2);
                    ev_byte[ev_n] = nd_dq_out;
                end
                ev_n = ev_n + 1;
                if (!nd_cle && !nd_ale) dat_n = dat_n + 1;
                if (nd_cle && nd_dq_out == CMD_STATUS) cmd70_n = cmd70_n + 1;
            end
            if (!nd_re_n && re_d) begin
                rd_n = rd_n + 1;
                if (rd_n == 1) rd_t0 = cyc;
                if (rd_n == 2) rd_t1 = cyc;
            end
            we_d = nd_we_n;
            re_d = nd_re_n;
        end
    end

    // stream description
    int          n_jmp = 0;
    int          jmp_at [4];
    logic [15:0] jmp_col [4];

    function automatic logic [7:0] data_of(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    int         exp_n;
    int         exp_kind [64];
    logic [7:0] exp_byte [64];

    task automatic push(input int k, input logic [7:0] b);
        if (exp_n < 64) begin
            exp_kind[exp_n] = k;
            exp_byte[exp_n] = b;
        end
        exp_n = exp_n + 1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests = n_tests + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic feed(input int len);
        for (int i = 0; i < len; i++) begin
            logic j;
            logic [15:0] jc;
            j = 1'b0;
            jc = '0;
            for (int k = 0; k < n_jmp; k++) begin
                if (jmp_at[k] == i) begin
                    j = 1'b1;
                    jc = jmp_col[k];
                end
            end
            @(negedge clk);
            din_valid = 1'b1; din_data = data_of(i); din_jump = j; din_col = jc;
            #1;
            while (!din_ready) begin
                @(negedge clk);
                #1;
            end
            @(posedge clk);
        end
        @(negedge clk);
        din_valid = 1'b0;
        din_jump  = 1'b0;
    endtask

    int pulse_ok;

    task automatic wait_done(output logic [1:0] res);
        @(negedge clk);
        while (!done_valid) @(negedge clk);
        res = done_result;
        @(negedge clk);
        pulse_ok = (!done_valid && req_ready) ? 1 : 0;
    endtask

    task automatic run_prog(input string req, input logic [23:0] row, input logic [15:0] col,
                            input int len, input int rdy_after, input logic fbit,
                            input logic [1:0] exp_res, input bit chk_log);
        logic [1:0] res;
        int bad_at;
        @(posedge clk);
        clr_log = 1'b1; ready_after = rdy_after; fail_flag = fbit;
        @(posedge clk);
        clr_log = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_row = row; req_col = col; req_len = 15'(len);
        @(posedge clk);
        #1 req_valid = 1'b0;
        if (exp_res == RES_REJECT) begin
            wait_done(res);
        end else begin
            fork
                feed(len);
                wait_done(res);
            join
        end
        chk(req, "result code", int'(res), int'(exp_res));
        chk("R10", "single-cycle done then ready", pulse_ok, 1);
        if (exp_res == RES_REJECT) chk(req, "bus cycles on refused request", ev_n, 0);
        if (chk_log) begin
            exp_n = 0;
            push(0, CMD_LOAD);
            push(1, col[7:0]); push(1, col[15:8]);
            push(1, row[7:0]); push(1, row[15:8]); push(1, row[23:16]);
            for (int i = 0; i < len; i++) begin
                for (int k = 0; k < n_jmp; k++) begin
                    if (jmp_at[k] == i) begin
                        push(0, CMD_COLJMP);
                        push(1, jmp_col[k][7:0]);
                        push(1, jmp_col[k][15:8]);
                    end
                end
                push(2, data_of(i));
            end
            push(0, CMD_CONFIRM);
            push(0, CMD_STATUS);
            chk(req, "bus write cycle count", ev_n, exp_n);
            bad_at = -1;
            for (int i = 0; i < exp_n && i < 64; i++) begin
                if (bad_at < 0 && (ev_kind[i] != exp_kind[i] || ev_byte[i] != exp_byte[i]))
                    bad_at = i;
            end
            chk(req, "first mismatching bus cycle index", bad_at, -1);
        end
    endtask

    // R9 R10: state after reset
    task automatic t_reset();
        @(negedge clk);
        chk("R10", "req_ready after reset", int'(req_ready), 1);
        chk("R10", "done_valid after reset", int'(done_valid), 0);
        chk("R9", "strobes idle after reset", int'({nd_we_n, nd_re_n, nd_cle, nd_ale}), 12);
    endtask

    // R1 R2 R4 R5 R6: contiguous load, busy for two reads with bit 0 set
    task automatic t_basic();
        n_jmp = 0;
        run_prog("R1 R2 R4", 24'h000105, 16'h0123, 6, 2, 1'b0, RES_PASS, 1'b1);
        chk("R6", "pass despite bit 0 while busy", int'(done_result), int'(RES_PASS));
        chk("R5", "status command count", cmd70_n, 1);
        chk("R5", "status read count", rd_n, 3);
        chk("R5", "status read spacing", rd_t1 - rd_t0, POLL_GAP);
    endtask

    // R3: jumps before the first byte and in the middle
    task automatic t_jump();
        n_jmp = 3;
        jmp_at[0] = 0; jmp_col[0] = 16'h0400;
        jmp_at[1] = 3; jmp_col[1] = 16'h0A0B;
        jmp_at[2] = 4; jmp_col[2] = 16'h4321;
        run_prog("R3", 24'h000200, 16'h0010, 7, 0, 1'b0, RES_PASS, 1'b1);
        n_jmp = 0;
    endtask

    // R6: fail bit reported once ready
    task automatic t_fail();
        run_prog("R6", 24'h000300, 16'h0000, 3, 3, 1'b1, RES_FAIL, 1'b1);
        chk("R6", "reads until ready", rd_n, 4);
    endtask

    // R7: device never ready
    task automatic t_timeout();
        run_prog("R7", 24'h000500, 16'h0002, 2, 100000, 1'b0, RES_TIMEOUT, 1'b1);
        chk("R5", "single status command on timeout", cmd70_n, 1);
    endtask

    // R4: length bounds
    task automatic t_len();
        run_prog("R4", 24'h000700, 16'h0000, 0, 0, 1'b0, RES_REJECT, 1'b0);
        run_prog("R4", 24'h000700, 16'h0000, MAX_BYTES + 1, 0, 1'b0, RES_REJECT, 1'b0);
    endtask

    // R8: page order within a block
    task automatic t_order();
        run_prog("R8", 24'h000105, 16'h0000, 1, 0, 1'b0, RES_REJECT, 1'b0);
        run_prog("R8", 24'h000104, 16'h0000, 1, 0, 1'b0, RES_REJECT, 1'b0);
        run_prog("R8", 24'h000106, 16'h0000, 2, 0, 1'b0, RES_PASS, 1'b1);
        run_prog("R8", 24'h000900, 16'h0000, 1, 0, 1'b0, RES_PASS, 1'b0);
    endtask

    // R2 R4: full page register load
    task automatic t_maxlen();
        run_prog("R4", 24'h000600, 16'h0000, MAX_BYTES, 0, 1'b0, RES_PASS, 1'b0);
        chk("R2", "data cycles on full load", dat_n, MAX_BYTES);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_basic();
        t_jump();
        t_fail();
        t_timeout();
        t_len();
        t_order();
        t_maxlen();
        repeat (4) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests = n_tests + 1;
        n_fail  = n_fail + 1;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule